// File: doc/BRIEF.md
# Accumulator Operate Microinstruction Unit

This unit executes the operate instructions of a 12-bit single-accumulator processor. It takes the instruction word, the current link and accumulator (L'AC), the multiplier-quotient register (MQ), the front-panel switch value, a user-mode flag and the page bits of the current address. It returns the new L'AC and MQ, plus a skip, halt or user-trap request for the sequencer.

Three instruction groups are decoded. Group 1 clears, complements, increments and rotates L'AC. Group 2 tests the accumulator and link and can skip, OR in the switch value or halt. Group 3 moves data between AC and MQ. Each group applies its micro-operations in a fixed order within one instruction. The unit does not fetch instructions or touch memory. Its result is registered one clock after a valid strobe.

Top module: `opr_unit`

## Requirements
- R1: When `valid` is high at a rising edge, the results appear on the outputs after that edge and `res_vld` is high for that one cycle. `skip`, `halt` and `user_trap` are high only in the cycle after an accepted instruction. With `valid` low, the data outputs hold their values.
- R2: Group 1 is selected by instr[11:8] = 4'b1110. Clear AC (instr[7]) and clear L (instr[6]) act first. Complement AC (instr[5]) and complement L (instr[4]) then act on the cleared values.
- R3: The group 1 increment (instr[0]) follows the complement step. It adds one to the 13-bit L'AC, so a carry out of AC toggles the link.
- R4: The group 1 rotate code instr[3:1] is applied after the increment. Code 1 swaps the 6-bit halves of AC and keeps L. Code 2 rotates L'AC left by one and code 3 left by two. Code 4 rotates right by one and code 5 right by two.
- R5: Rotate code 6 sets AC to AC AND instr. Code 7 sets AC to {page[4:0], instr[6:0]}. Both codes keep the link.
- R6: Group 2 is selected by instr[11:8] = 4'b1111 with instr[0] = 0. The test bits are AC negative (instr[6]), AC zero (instr[5]) and link set (instr[4]). With the reverse bit instr[3] clear, the unit skips if any selected test holds. With instr[3] set, it skips only if no selected test holds, so instr[3] alone always skips.
- R7: In group 2 the skip is decided on the incoming AC. Clear AC (instr[7]) then acts, then switch-OR (instr[2]) ORs `sw_in` into AC. Halt (instr[1]) raises `halt`.
- R8: When `user_mode` is set and instr[2] or instr[1] is present, `user_trap` is raised instead. The switch OR and the halt are both suppressed. The skip and the clear still act.
- R9: Group 3 is selected by instr[11:8] = 4'b1111 with instr[0] = 1. Clear AC (instr[7]) acts first. Then instr[4] copies AC into MQ and clears AC. Then instr[6] ORs the incoming MQ into AC, so instr[6] and instr[4] together exchange AC and MQ. The link is never changed.
- R10: An instruction whose instr[11:9] is not 3'b111 leaves L, AC and MQ unchanged and raises no request. Groups 1 and 2 leave MQ unchanged.
- R11: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| valid | input | 1 | Qualifies the instruction and operands |
| instr | input | 12 | Instruction word |
| link_in | input | 1 | Current link |
| ac_in | input | 12 | Current accumulator |
| mq_in | input | 12 | Current MQ |
| sw_in | input | 12 | Switch register value |
| user_mode | input | 1 | User-mode flag |
| page_in | input | 5 | Page bits of the current address |
| res_vld | output | 1 | Result valid pulse |
| link_out | output | 1 | New link |
| ac_out | output | 12 | New accumulator |
| mq_out | output | 12 | New MQ |
| skip | output | 1 | Skip request pulse |
| halt | output | 1 | Halt request pulse |
| user_trap | output | 1 | User trap request pulse |

## Verification
The only state is the output register, so any fault in the micro-operation order shows up on `ac_out` or `link_out` one cycle after the strobe. Examples are a complement applied before the clear, or a skip tested after the clear. Exercising every clear/complement combination with the increment that carries out of AC catches reordering of the group 1 steps. A stale pulse or a data output that changes while `valid` is low is visible in the very next cycle.

// File: rtl/opr_unit.sv
module opr_unit #(
  parameter int W  = 12,
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic [W-1:0]  instr,
  input  logic          link_in,
  input  logic [W-1:0]  ac_in,
  input  logic [W-1:0]  mq_in,
  input  logic [W-1:0]  sw_in,
  input  logic          user_mode,
  input  logic [PW-1:0] page_in,
  output logic          res_vld,
  output logic          link_out,
  output logic [W-1:0]  ac_out,
  output logic [W-1:0]  mq_out,
  output logic          skip,
  output logic          halt,
  output logic          user_trap
);
  localparam int OFW = W - PW;
  localparam int HW  = W / 2;

  wire is_opr = &instr[W-1:W-3];
  wire grp1   = is_opr & ~instr[W-4];
  wire grp2   = is_opr &  instr[W-4] & ~instr[0];
  wire grp3   = is_opr &  instr[W-4] &  instr[0];

  logic          l1, l1c;
  logic [W-1:0]  a1, a1c;
  logic [W:0]    v1, r1;
  always_comb begin
    l1  = instr[6] ? 1'b0 : link_in;
    a1  = instr[7] ? '0 : ac_in;
    l1c = instr[4] ? ~l1 : l1;
    a1c = instr[5] ? ~a1 : a1;
    v1  = {l1c, a1c} + {{W{1'b0}}, instr[0]};
    case (instr[3:1])
      3'd1:    r1 = {v1[W], v1[HW-1:0], v1[W-1:HW]};
      3'd2:    r1 = {v1[W-1:0], v1[W]};
      3'd3:    r1 = {v1[W-2:0], v1[W:W-1]};
      3'd4:    r1 = {v1[0], v1[W:1]};
      3'd5:    r1 = {v1[1:0], v1[W:2]};
      3'd6:    r1 = {v1[W], v1[W-1:0] & instr};
      3'd7:    r1 = {v1[W], page_in, instr[OFW-1:0]};
      default: r1 = v1;
    endcase
  end

  wire          cond2 = (instr[6] & ac_in[W-1]) | (instr[5] & (ac_in == '0)) | (instr[4] & link_in);
  wire          sk2   = cond2 ^ instr[3];
  wire          priv2 = instr[2] | instr[1];
  wire          trap2 = user_mode & priv2;
  wire [W-1:0]  a2    = (instr[7] ? '0 : ac_in) | ((instr[2] & ~user_mode) ? sw_in : '0);
  wire          hlt2  = instr[1] & ~user_mode;

  wire [W-1:0]  a3c = instr[7] ? '0 : ac_in;
  wire [W-1:0]  m3  = instr[4] ? a3c : mq_in;
  wire [W-1:0]  a3  = (instr[4] ? '0 : a3c) | (instr[6] ? mq_in : '0);

  logic         n_link, n_skip, n_halt, n_trap;
  logic [W-1:0] n_ac, n_mq;
  always_comb begin
    n_link = link_in;
    n_ac   = ac_in;
    n_mq   = mq_in;
    n_skip = 1'b0;
    n_halt = 1'b0;
    n_trap = 1'b0;
    if (grp1) begin
      n_link = r1[W];
      n_ac   = r1[W-1:0];
    end else if (grp2) begin
      n_ac   = a2;
      n_skip = sk2;
      n_halt = hlt2;
      n_trap = trap2;
    end else if (grp3) begin
      n_ac = a3;
      n_mq = m3;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld   <= 1'b0;
      link_out  <= 1'b0;
      ac_out    <= '0;
      mq_out    <= '0;
      skip      <= 1'b0;
      halt      <= 1'b0;
      user_trap <= 1'b0;
    end else begin
      res_vld   <= valid;
      skip      <= valid & n_skip;
      halt      <= valid & n_halt;
      user_trap <= valid & n_trap;
      if (valid) begin
        link_out <= n_link;
        ac_out   <= n_ac;
        mq_out   <= n_mq;
      end
    end
  end

  // R1
  pulse_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(valid) |-> !(skip || halt || user_trap));
  // R1
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(valid) |-> ($stable(ac_out) && $stable(mq_out) && $stable(link_out)));
  // R8
  user_no_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(valid && user_mode) |-> !halt);
  // R8
  halt_trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(halt && user_trap));
  // R9
  grp3_link_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(valid && grp3) |-> (link_out == $past(link_in)));
  // R10
  non_opr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(valid && !is_opr) |-> (ac_out == $past(ac_in) && mq_out == $past(mq_in) && !skip));
endmodule

// File: tb/opr_unit_test.sv
module opr_unit_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [11:0] instr;
    logic        l;
    logic [11:0] ac;
    logic [11:0] mq;
    logic [11:0] sw;
    logic        usr;
    logic [4:0]  page;
    logic        el;
    logic [11:0] eac;
    logic [11:0] emq;
    logic        esk;
    logic        eh;
    logic        et;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t TBL [NV] = '{
    '{12'o7001, 1'b0, 12'o7777, 12'o0000, 12'o0000, 1'b0, 5'd0,  1'b1, 12'o0000, 12'o0000, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 carry
    '{12'o7241, 1'b1, 12'o1234, 12'o0000, 12'o0000, 1'b0, 5'd0,  1'b0, 12'o0000, 12'o0000, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 order
    '{12'o7002, 1'b1, 12'o1234, 12'o0000, 12'o0000, 1'b0, 5'd0,  1'b1, 12'o3412, 12'o0000, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 swap
    '{12'o7004, 1'b1, 12'o4000, 12'o0000, 12'o0000, 1'b0, 5'd0,  1'b1, 12'o0001, 12'o0000, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 left 1
    '{12'o7006, 1'b0, 12'o6000, 12'o0000, 12'o0000, 1'b0, 5'd0,  1'b1, 12'o0001, 12'o0000, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 left 2
    '{12'o7010, 1'b1, 12'o0001, 12'o0000, 12'o0000, 1'b0, 5'd0,  1'b1, 12'o4000, 12'o0000, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 right 1
    '{12'o7012, 1'b0, 12'o0003, 12'o0000, 12'o0000, 1'b0, 5'd0,  1'b1, 12'o4000, 12'o0000, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 right 2
    '{12'o7014, 1'b1, 12'o7777, 12'o0000, 12'o0000, 1'b0, 5'd0,  1'b1, 12'o7014, 12'o0000, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 and
    '{12'o7016, 1'b0, 12'o1111, 12'o0000, 12'o0000, 1'b0, 5'd21, 1'b0, 12'o5216, 12'o0000, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 page
    '{12'o7500, 1'b0, 12'o4000, 12'o0000, 12'o0000, 1'b0, 5'd0,  1'b0, 12'o4000, 12'o0000, 1'b1, 1'b0, 1'b0, 4'd6},  // R6 neg
    '{12'o7640, 1'b0, 12'o0000, 12'o0000, 12'o0000, 1'b0, 5'd0,  1'b0, 12'o0000, 12'o0000, 1'b1, 1'b0, 1'b0, 4'd7},  // R7 zero+clear
    '{12'o7420, 1'b0, 12'o1234, 12'o0000, 12'o0000, 1'b0, 5'd0,  1'b0, 12'o1234, 12'o0000, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 link clear
    '{12'o7510, 1'b0, 12'o4000, 12'o0000, 12'o0000, 1'b0, 5'd0,  1'b0, 12'o4000, 12'o0000, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 rev neg
    '{12'o7550, 1'b1, 12'o0001, 12'o0000, 12'o0000, 1'b0, 5'd0,  1'b1, 12'o0001, 12'o0000, 1'b1, 1'b0, 1'b0, 4'd6},  // R6 rev all
    '{12'o7410, 1'b0, 12'o0000, 12'o0000, 12'o0000, 1'b0, 5'd0,  1'b0, 12'o0000, 12'o0000, 1'b1, 1'b0, 1'b0, 4'd6},  // R6 always
    '{12'o7430, 1'b0, 12'o0000, 12'o0000, 12'o0000, 1'b0, 5'd0,  1'b0, 12'o0000, 12'o0000, 1'b1, 1'b0, 1'b0, 4'd6},  // R6 rev link
    '{12'o7604, 1'b0, 12'o1234, 12'o0000, 12'o0070, 1'b0, 5'd0,  1'b0, 12'o0070, 12'o0000, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 clear+or
    '{12'o7402, 1'b1, 12'o0055, 12'o0000, 12'o0000, 1'b0, 5'd0,  1'b1, 12'o0055, 12'o0000, 1'b0, 1'b1, 1'b0, 4'd7},  // R7 halt
    '{12'o7406, 1'b0, 12'o1234, 12'o0000, 12'o7777, 1'b1, 5'd0,  1'b0, 12'o1234, 12'o0000, 1'b0, 1'b0, 1'b1, 4'd8},  // R8 trap
    '{12'o7700, 1'b0, 12'o4000, 12'o0000, 12'o0000, 1'b1, 5'd0,  1'b0, 12'o0000, 12'o0000, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 no trap
    '{12'o7421, 1'b1, 12'o1234, 12'o5670, 12'o0000, 1'b0, 5'd0,  1'b1, 12'o0000, 12'o1234, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 to MQ
    '{12'o7501, 1'b0, 12'o0012, 12'o0300, 12'o0000, 1'b0, 5'd0,  1'b0, 12'o0312, 12'o0300, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 or MQ
    '{12'o7521, 1'b0, 12'o1234, 12'o5670, 12'o0000, 1'b0, 5'd0,  1'b0, 12'o5670, 12'o1234, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 swap
    '{12'o7701, 1'b1, 12'o1234, 12'o0055, 12'o0000, 1'b0, 5'd0,  1'b1, 12'o0055, 12'o0055, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 clear first
    '{12'o1234, 1'b1, 12'o2222, 12'o4321, 12'o7777, 1'b0, 5'd0,  1'b1, 12'o2222, 12'o4321, 1'b0, 1'b0, 1'b0, 4'd10}, // R10 non-opr
    '{12'o6001, 1'b0, 12'o3333, 12'o0000, 12'o0000, 1'b0, 5'd0,  1'b0, 12'o3333, 12'o0000, 1'b0, 1'b0, 1'b0, 4'd10}, // R10 non-opr
    '{12'o7200, 1'b0, 12'o1234, 12'o1357, 12'o0000, 1'b0, 5'd0,  1'b0, 12'o0000, 12'o1357, 1'b0, 1'b0, 1'b0, 4'd10}  // R10 MQ kept
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [11:0] instr = '0, ac_in = '0, mq_in = '0, sw_in = '0;
  logic        link_in = 1'b0, user_mode = 1'b0;
  logic [4:0]  page_in = '0;
  logic        res_vld, link_out, skip, halt, user_trap;
  logic [11:0] ac_out, mq_out;
  int          errors = 0, checks = 0;
  bit          finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opr_unit uut (
    .clk(clk), .rst_n(rst_n), .valid(valid), .instr(instr), .link_in(link_in),
    .ac_in(ac_in), .mq_in(mq_in), .sw_in(sw_in), .user_mode(user_mode), .page_in(page_in),
    .res_vld(res_vld), .link_out(link_out), .ac_out(ac_out), .mq_out(mq_out),
    .skip(skip), .halt(halt), .user_trap(user_trap)
  );

  task automatic apply(input vec_t v);
    @(negedge clk);
    instr = v.instr; link_in = v.l; ac_in = v.ac; mq_in = v.mq;
    sw_in = v.sw; user_mode = v.usr; page_in = v.page; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic check(input vec_t v);
    logic [40:0] act, exp;
    act = {res_vld, link_out, ac_out, mq_out, skip, halt, user_trap};
    exp = {1'b1, v.el, v.eac, v.emq, v.esk, v.eh, v.et};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d instr=%o vld/l/ac/mq/sk/h/t actual=%b_%b_%o_%o_%b%b%b expected=%b_%b_%o_%o_%b%b%b",
        v.req, v.instr, act[40], act[39], act[38:27], act[26:15], act[2], act[1], act[0],
        exp[40], exp[39], exp[38:27], exp[26:15], exp[2], exp[1], exp[0]);
    end
  endtask

  function automatic vec_t g1_model(input logic [3:0] bits, input logic l, input logic [11:0] ac);
    vec_t v;
    logic nl;
    logic [11:0] na;
    nl = bits[2] ? 1'b0 : l;
    na = bits[3] ? 12'o0000 : ac;
    if (bits[1]) na = ~na;
    if (bits[0]) nl = ~nl;
    v = '{12'o7000 | {4'b0, bits, 4'b0}, l, ac, 12'o0101, 12'o0000, 1'b0, 5'd0,
          nl, na, 12'o0101, 1'b0, 1'b0, 1'b0, 4'd2};
    return v;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    checks++;
    if ({res_vld, link_out, ac_out, mq_out, skip, halt, user_trap} !== '0) begin
      errors++;
      $display("FAIL R11 reset outputs actual=%b_%o_%o_%b%b%b expected=0_0000_0000_000",
        link_out, ac_out, mq_out, skip, halt, user_trap);
    end
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i]);
      check(TBL[i]);
    end

    // R2 every clear/complement combination on two operands
    for (int b = 0; b < 16; b++) begin
      vec_t v;
      v = g1_model(b[3:0], 1'b0, 12'o5252);
      apply(v); check(v);
      v = g1_model(b[3:0], 1'b1, 12'o0707);
      apply(v); check(v);
    end

    // R1 skip pulse lasts one cycle and outputs hold while idle
    apply(TBL[14]);
    check(TBL[14]);
    instr = 12'o7200; ac_in = 12'o7777; link_in = 1'b1;
    @(negedge clk);
    checks++;
    if (skip !== 1'b0 || res_vld !== 1'b0 || ac_out !== 12'o0000 || link_out !== 1'b0) begin
      errors++;
      $display("FAIL R1 idle cycle actual=sk%b vld%b l%b ac=%o expected=sk0 vld0 l0 ac=0000",
        skip, res_vld, link_out, ac_out);
    end

    // R8 trap on halt bit alone, halt suppressed
    begin
      vec_t v;
      v = '{12'o7402, 1'b0, 12'o0017, 12'o0000, 12'o0000, 1'b1, 5'd0,
            1'b0, 12'o0017, 12'o0000, 1'b0, 1'b0, 1'b1, 4'd8};
      apply(v); check(v);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule